// File: doc/BRIEF.md
# Shared-Bus Ownership Controller

This block decides when a processor may drive a bus that it shares with other masters. An external arbiter owns the priority decision. The controller raises a request line while the core has an access waiting and watches a grant line from the arbiter. It asserts a bus-driven line whenever it is the active (explicit) owner. When the arbiter grants the bus but the core has nothing to send, the controller holds the bus only implicitly: it neither drives the bus nor asserts bus-driven.

A bus cycle opens with a one-clock transfer-start pulse. A cycle is either one beat or a burst of `BURST_BEATS` beats, chosen per access. A beat counter closes the cycle on the last acknowledge, or at once on a bus-error termination. The whole burst is treated as one cycle that cannot be broken. If the arbiter removes grant in the middle of a cycle, the controller finishes the cycle and only then lets go of the bus. The enable for the address, attribute and control drivers follows bus-driven with one register of delay.

Core protocol: the core holds `core_req` (with `core_burst` stable) until it sees `ts_o` high, and it lowers `core_req` during that cycle unless it has a further access waiting.

Top module: `bus_own_ctrl`

## Requirements
- R1: While `rst` is sampled high on a rising edge, every output is 0 in the following cycle, whatever the other inputs are.
- R2: `req_o` is 1 in the cycle after an edge where `core_req` is 1 and no transfer starts. It is 0 in the cycle after an edge where `core_req` is 0, or where a transfer starts. This holds whatever the value of `grant_i`.
- R3: A transfer starts on an edge where `core_req`=1 and `grant_i`=1 and no cycle is in progress. In the next cycle `ts_o`=1 and `driven_o`=1, and `ts_o` stays high for exactly one cycle.
- R4: After an edge with `grant_i`=1 that neither starts a transfer nor finds the block as explicit owner, `implicit_o`=1 and both `driven_o` and `drv_en_o` are 0.
- R5: An explicit owner with no cycle in progress keeps `driven_o`=1 while `grant_i` stays 1. It clears `driven_o` in the cycle after an edge that samples `grant_i`=0.
- R6: During a cycle, `driven_o` stays 1 even after `grant_i` falls. If `grant_i` is 0 at the edge carrying the final termination, `driven_o` is 0 in the next cycle.
- R7: `core_burst`=1 selects a cycle of `BURST_BEATS` (default 4) acknowledged beats, and `core_burst`=0 selects one beat. `cycle_end_o` pulses for one cycle after the edge with the final `ack_i`, and not before.
- R8: `err_i`=1 on any beat of a cycle ends that cycle at that edge: `cycle_end_o` pulses in the next cycle, and the release rule of R6 applies.
- R9: `drv_en_o` equals the value `driven_o` had one cycle earlier.
- R10: `ack_i` and `err_i` outside a cycle are ignored: no `cycle_end_o` pulse, and no change to `driven_o`.
- R11: No new transfer starts while a cycle is in progress (`ts_o` stays 0 through every beat). A request held across the cycle starts on the edge after the final termination if grant is still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| core_req | input | 1 | Core has an access waiting |
| core_burst | input | 1 | 1 = burst access of BURST_BEATS beats, 0 = single beat |
| grant_i | input | 1 | Bus grant from the external arbiter |
| ack_i | input | 1 | Transfer acknowledge for one beat |
| err_i | input | 1 | Bus-error termination |
| req_o | output | 1 | Bus request to the arbiter, always driven |
| driven_o | output | 1 | Explicit bus ownership, always driven |
| implicit_o | output | 1 | Implicit ownership (granted, idle, not driving) |
| ts_o | output | 1 | Transfer start, one clock per bus cycle |
| drv_en_o | output | 1 | Enable for address, attribute and control drivers |
| cycle_end_o | output | 1 | One-clock pulse after a cycle terminates |

## Verification
The bench sweeps both access lengths. For each length it tries every beat at which grant may fall (or no fall at all) against every beat at which a bus error may arrive (or none). This separates release at the end of the cycle from early release, and an error-cut cycle from a counted one. Each run starts from implicit ownership, so the move from implicit to explicit is covered every time. Directed runs cover requests made without grant, terminations sent while no cycle is open, and a request held through a burst that must start back-to-back after it.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [1:0] {
    MST_NONE     = 2'd0,
    MST_IMPLICIT = 2'd1,
    MST_EXPLICIT = 2'd2
  } mst_mode_e;

  // Beats in one bus cycle for the requested access length.
  function automatic int unsigned beats_for(logic burst, int unsigned burst_beats);
    return burst ? burst_beats : 32'd1;
  endfunction

  // Ownership state after this edge.
  function automatic mst_mode_e next_mode(mst_mode_e cur, logic grant, logic start,
                                          logic busy, logic end_fire);
    if (start) return MST_EXPLICIT;
    if (busy && !end_fire) return MST_EXPLICIT;
    if (cur == MST_EXPLICIT && grant) return MST_EXPLICIT;
    if (grant) return MST_IMPLICIT;
    return MST_NONE;
  endfunction

endpackage

// File: rtl/bus_own_req.sv
module bus_own_req (
  input  logic clk,
  input  logic rst,
  input  logic core_req,
  input  logic grant_i,
  input  logic busy,
  output logic start_fire,
  output logic req_o,
  output logic ts_o
);

  assign start_fire = core_req && grant_i && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
      ts_o  <= 1'b0;
    end else begin
      req_o <= core_req && !start_fire;
      ts_o  <= start_fire;
    end
  end

endmodule

// File: rtl/bus_own_beats.sv
module bus_own_beats #(
  parameter int unsigned BURST_BEATS = 4,
  localparam int unsigned CNT_W = $clog2(BURST_BEATS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_fire,
  input  logic core_burst,
  input  logic ack_i,
  input  logic err_i,
  output logic busy,
  output logic end_fire
);
  import bus_own_pkg::*;

  logic [CNT_W-1:0] beats_left;
  logic [CNT_W-1:0] load_val;
  logic             last_beat;

  assign load_val  = CNT_W'(beats_for(core_burst, BURST_BEATS));
  assign last_beat = (beats_left == CNT_W'(1));
  assign end_fire  = busy && (err_i || (ack_i && last_beat));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      beats_left <= '0;
    end else if (start_fire) begin
      busy       <= 1'b1;
      beats_left <= load_val;
    end else if (end_fire) begin
      busy       <= 1'b0;
      beats_left <= '0;
    end else if (busy && ack_i) begin
      beats_left <= beats_left - CNT_W'(1);
    end
  end

endmodule

// File: rtl/bus_own_mst.sv
module bus_own_mst (
  input  logic clk,
  input  logic rst,
  input  logic grant_i,
  input  logic start_fire,
  input  logic busy,
  input  logic end_fire,
  output logic driven_o,
  output logic implicit_o,
  output logic drv_en_o,
  output logic cycle_end_o
);
  import bus_own_pkg::*;

  mst_mode_e mode_q;
  mst_mode_e mode_d;

  always_comb mode_d = next_mode(mode_q, grant_i, start_fire, busy, end_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MST_NONE;
      drv_en_o    <= 1'b0;
      cycle_end_o <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      drv_en_o    <= (mode_q == MST_EXPLICIT);
      cycle_end_o <= end_fire;
    end
  end

  assign driven_o   = (mode_q == MST_EXPLICIT);
  assign implicit_o = (mode_q == MST_IMPLICIT);

endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl #(
  parameter int unsigned BURST_BEATS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic core_req,
  input  logic core_burst,
  input  logic grant_i,
  input  logic ack_i,
  input  logic err_i,
  output logic req_o,
  output logic driven_o,
  output logic implicit_o,
  output logic ts_o,
  output logic drv_en_o,
  output logic cycle_end_o
);

  logic start_fire;
  logic busy;
  logic end_fire;

  bus_own_req u_req (
    .clk        (clk),
    .rst        (rst),
    .core_req   (core_req),
    .grant_i    (grant_i),
    .busy       (busy),
    .start_fire (start_fire),
    .req_o      (req_o),
    .ts_o       (ts_o)
  );

  bus_own_beats #(.BURST_BEATS(BURST_BEATS)) u_beats (
    .clk        (clk),
    .rst        (rst),
    .start_fire (start_fire),
    .core_burst (core_burst),
    .ack_i      (ack_i),
    .err_i      (err_i),
    .busy       (busy),
    .end_fire   (end_fire)
  );

  bus_own_mst u_mst (
    .clk         (clk),
    .rst         (rst),
    .grant_i     (grant_i),
    .start_fire  (start_fire),
    .busy        (busy),
    .end_fire    (end_fire),
    .driven_o    (driven_o),
    .implicit_o  (implicit_o),
    .drv_en_o    (drv_en_o),
    .cycle_end_o (cycle_end_o)
  );

endmodule

// File: rtl/bus_own_ctrl_chk.sv
module bus_own_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic core_req,
  input logic grant_i,
  input logic ack_i,
  input logic err_i,
  input logic req_o,
  input logic driven_o,
  input logic implicit_o,
  input logic ts_o,
  input logic drv_en_o,
  input logic cycle_end_o,
  input logic start_fire,
  input logic busy,
  input logic end_fire
);

  logic past_rst = 1'b0;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (past_rst) begin
      AST_RESET_QUIET: assert (!req_o && !driven_o && !implicit_o && !ts_o && !drv_en_o && !cycle_end_o); // R1
    end
  end

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst) !core_req |=> !req_o); // R2
  AST_START_DRIVES: assert property (@(posedge clk) disable iff (rst) start_fire |=> (ts_o && driven_o)); // R3
  AST_TS_PULSE: assert property (@(posedge clk) disable iff (rst) ts_o |=> !ts_o); // R3
  AST_IMPLICIT_QUIET: assert property (@(posedge clk) disable iff (rst) implicit_o |-> (!driven_o && !drv_en_o)); // R4
  AST_HOLD_WITH_GRANT: assert property (@(posedge clk) disable iff (rst) (driven_o && grant_i) |=> driven_o); // R5
  AST_HOLD_IN_CYCLE: assert property (@(posedge clk) disable iff (rst) (busy && !end_fire) |=> driven_o); // R6
  AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (rst) (end_fire && !grant_i) |=> !driven_o); // R6
  AST_END_NEEDS_TERM: assert property (@(posedge clk) disable iff (rst) cycle_end_o |-> $past(ack_i || err_i)); // R7
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst) (busy && err_i) |=> cycle_end_o); // R8
  AST_DRV_EN_LAG: assert property (@(posedge clk) disable iff (rst) drv_en_o |=> 1'b1 ##0 (drv_en_o == $past(driven_o))); // R9
  AST_IDLE_TERM_IGNORED: assert property (@(posedge clk) disable iff (rst) (!busy && (ack_i || err_i)) |=> !cycle_end_o); // R10
  AST_NO_TS_IN_CYCLE: assert property (@(posedge clk) disable iff (rst) ts_o |-> !$past(busy)); // R11

endmodule

bind bus_own_ctrl bus_own_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .core_req    (core_req),
  .grant_i     (grant_i),
  .ack_i       (ack_i),
  .err_i       (err_i),
  .req_o       (req_o),
  .driven_o    (driven_o),
  .implicit_o  (implicit_o),
  .ts_o        (ts_o),
  .drv_en_o    (drv_en_o),
  .cycle_end_o (cycle_end_o),
  .start_fire  (start_fire),
  .busy        (busy),
  .end_fire    (end_fire)
);

// File: tb/bus_own_ctrl_tb.sv
module bus_own_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BEATS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_req = 1'b0, core_burst = 1'b0, grant_i = 1'b0, ack_i = 1'b0, err_i = 1'b0;
  logic req_o, driven_o, implicit_o, ts_o, drv_en_o, cycle_end_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_own_ctrl #(.BURST_BEATS(BEATS)) u_dut (
    .clk(clk), .rst(rst), .core_req(core_req), .core_burst(core_burst),
    .grant_i(grant_i), .ack_i(ack_i), .err_i(err_i), .req_o(req_o),
    .driven_o(driven_o), .implicit_o(implicit_o), .ts_o(ts_o),
    .drv_en_o(drv_en_o), .cycle_end_o(cycle_end_o)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Return to implicit ownership: grant off, then on, no request.
  task automatic to_implicit();
    grant_i = 1'b0; core_req = 1'b0;
    step(); step();
    grant_i = 1'b1;
    step();
    chk(implicit_o, 1'b1, "R4 implicit_o with idle grant");
    chk(driven_o, 1'b0, "R4 driven_o low when implicit");
    step();
    chk(drv_en_o, 1'b0, "R4 drv_en_o low when implicit");
  endtask

  // One cycle: len by burst, grant falls before beat drop_at, error on beat err_at.
  task automatic run_cycle(input logic burst, input int drop_at, input int err_at);
    int n;
    int last;
    logic exp_drv;
    n = burst ? BEATS : 1;
    last = (err_at >= 0 && err_at < n - 1) ? err_at : n - 1;
    exp_drv = !(drop_at >= 0 && drop_at <= last);
    to_implicit();
    core_req = 1'b1; core_burst = burst;
    step();
    chk(ts_o, 1'b1, "R3 ts_o after start");
    chk(driven_o, 1'b1, "R3 driven_o after start");
    chk(req_o, 1'b0, "R2 req_o low after start");
    chk(implicit_o, 1'b0, "R4 implicit_o leaves on start");
    core_req = 1'b0;
    for (int i = 0; i <= last; i++) begin
      if (i == drop_at) grant_i = 1'b0;
      if (i == err_at) err_i = 1'b1; else ack_i = 1'b1;
      step();
      ack_i = 1'b0; err_i = 1'b0;
      chk(ts_o, 1'b0, "R3 ts_o one cycle");
      if (i == last) begin
        chk(cycle_end_o, 1'b1, (err_at == i) ? "R8 end on error" : "R7 end on final ack");
        chk(driven_o, exp_drv, "R6 driven_o after cycle end");
      end else begin
        chk(cycle_end_o, 1'b0, "R7 no early end");
        chk(driven_o, 1'b1, "R6 driven_o held in cycle");
      end
    end
    step();
    chk(drv_en_o, exp_drv, "R9 drv_en_o follows driven_o");
    chk(cycle_end_o, 1'b0, "R7 cycle_end_o one cycle");
    if (exp_drv) begin
      chk(driven_o, 1'b1, "R5 explicit held with grant");
      grant_i = 1'b0;
      step();
      chk(driven_o, 1'b0, "R5 released on grant low");
      chk(drv_en_o, 1'b1, "R9 drv_en_o lags release");
      step();
      chk(drv_en_o, 1'b0, "R9 drv_en_o off after release");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset with busy-looking inputs
    grant_i = 1'b1; core_req = 1'b1; ack_i = 1'b1;
    @(negedge clk); step(); step();
    chk(req_o, 1'b0, "R1 req_o in reset");
    chk(ts_o, 1'b0, "R1 ts_o in reset");
    chk(driven_o, 1'b0, "R1 driven_o in reset");
    chk(implicit_o, 1'b0, "R1 implicit_o in reset");
    chk(drv_en_o, 1'b0, "R1 drv_en_o in reset");
    chk(cycle_end_o, 1'b0, "R1 cycle_end_o in reset");
    grant_i = 1'b0; core_req = 1'b0; ack_i = 1'b0;
    rst = 1'b0;
    step();

    // R2: request without grant
    core_req = 1'b1;
    step();
    chk(req_o, 1'b1, "R2 req_o without grant");
    chk(ts_o, 1'b0, "R2 no start without grant");
    step();
    chk(req_o, 1'b1, "R2 req_o held");
    core_req = 1'b0;
    step();
    chk(req_o, 1'b0, "R2 req_o dropped with core_req");

    // R10: terminations while idle
    ack_i = 1'b1; step();
    chk(cycle_end_o, 1'b0, "R10 idle ack ignored");
    ack_i = 1'b0; err_i = 1'b1; step();
    chk(cycle_end_o, 1'b0, "R10 idle err ignored");
    chk(driven_o, 1'b0, "R10 idle err no drive");
    err_i = 1'b0;

    // Sweep of length x grant-drop beat x error beat
    for (int b = 0; b < 2; b++) begin
      for (int d = -1; d < (b ? BEATS : 1); d++) begin
        for (int e = -1; e < (b ? BEATS : 1); e++) begin
          run_cycle(logic'(b), d, e);
        end
      end
    end

    // R11: request held across a burst, back-to-back start
    to_implicit();
    core_req = 1'b1; core_burst = 1'b1;
    step();
    chk(ts_o, 1'b1, "R11 first start");
    core_burst = 1'b0;
    for (int i = 0; i < BEATS; i++) begin
      ack_i = 1'b1;
      step();
      ack_i = 1'b0;
      chk(ts_o, 1'b0, "R11 no start inside cycle");
      chk(req_o, 1'b1, "R2 req_o for held request");
    end
    chk(cycle_end_o, 1'b1, "R7 burst end");
    step();
    chk(ts_o, 1'b1, "R11 back-to-back start");
    core_req = 1'b0;
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    chk(cycle_end_o, 1'b1, "R7 single beat end");
    chk(driven_o, 1'b1, "R5 driven_o kept with grant");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule